// File: doc/BRIEF.md
# Shifted Operand Generator With Carry

This combinational unit forms the second source operand of a 32-bit data-processing instruction, together with the carry bit that the shifter produces. It reads the low twelve bits of the instruction word. From those bits it chooses one of two forms. The first form is an 8-bit constant spun right by an even amount. The second form is a register value moved by one of four shift kinds. The amount for that move comes either from a 5-bit field in the instruction or from the low byte of a second register.

The unit presents the two register indices on its outputs, and the surrounding register file answers them. It returns the operand and the raw shifter carry. It also returns the carry value that is to be written, plus a write enable. The write enable is set only when the caller asks for a flag update and the operand is not being used as a load/store address offset. The register file, the ALU and the condition logic all stay outside the unit.

Top module: `shifted_operand_gen`

## Requirements
- R1: When `imm_form_i` is 1, `operand_o` is `op_field_i[7:0]` zero-extended and rotated right by twice `op_field_i[11:8]`. `shift_c_o` equals `carry_i` when that field is 0, and equals `operand_o[31]` otherwise.
- R2: `rm_idx_o` always equals `op_field_i[3:0]` and `rs_idx_o` always equals `op_field_i[11:8]`. In register form, `op_field_i[6:5]` picks the shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R3: In register form, `op_field_i[4]`=1 takes the shift amount from `rs_byte_i`. `op_field_i[4]`=0 takes it from `op_field_i[11:7]`.
- R4: For amounts from 1 to 31, the result is the register value shifted by that amount, and `shift_c_o` is the last bit moved out.
- R5: An amount of 0 from the register source, or an immediate logical-left amount of 0, gives `operand_o` = `rm_data_i` and `shift_c_o` = `carry_i`.
- R6: For register amounts of 32 or more: a logical shift by exactly 32 gives 0 with carry `rm[0]` (left) or `rm[31]` (right). A logical shift above 32 gives 0 with carry 0. An arithmetic right shift gives all copies of `rm[31]` with carry `rm[31]`. A rotate uses the amount modulo 32, and a nonzero multiple of 32 returns `rm` with carry `rm[31]`.
- R7: An immediate amount of 0 with logical right or arithmetic right behaves as an amount of 32.
- R8: An immediate amount of 0 with rotate right gives `{carry_i, rm[31:1]}` with carry `rm[0]`.
- R9: `carry_we_o` = `flag_upd_i & ~addr_mode_i`. `carry_o` equals `shift_c_o` when `carry_we_o` is 1, and equals `carry_i` otherwise.
- R10: While `addr_mode_i` is 1, `carry_we_o` is 0 and `carry_o` equals `carry_i`, whatever `flag_upd_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field_i | input | 12 | Low twelve bits of the instruction word |
| imm_form_i | input | 1 | 1 selects the rotated-constant form |
| rm_data_i | input | 32 | Register file read data for index `rm_idx_o` |
| rs_byte_i | input | 8 | Low byte of register file read data for index `rs_idx_o` |
| carry_i | input | 1 | Current carry flag |
| flag_upd_i | input | 1 | Caller requests flag update |
| addr_mode_i | input | 1 | Operand used as a load/store address offset |
| rm_idx_o | output | 4 | Index of the shifted register |
| rs_idx_o | output | 4 | Index of the amount register |
| operand_o | output | 32 | Second operand |
| shift_c_o | output | 1 | Raw shifter carry |
| carry_o | output | 1 | Carry value to be committed |
| carry_we_o | output | 1 | Carry flag write enable |

## Verification
The checks assume that `rm_data_i` and `rs_byte_i` have already settled for the indices currently on the outputs. This means the register file must answer the index outputs without delay. The bench meets this assumption with a register array that it reads through continuous assignments on the index outputs. It only changes that array and the inputs together, one clock edge before each comparison. The checks also assume that `op_field_i` carries no unknown bits, and every vector the bench applies is fully defined.

// File: rtl/opg_pkg.sv
package opg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;
endpackage

// File: rtl/opg_imm_rot.sv
module opg_imm_rot
  import opg_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [7:0]    imm_i,
  input  logic [3:0]    rot_i,
  input  logic          carry_i,
  output logic [DW-1:0] val_o,
  output logic          c_o
);
  localparam int unsigned RW = $clog2(DW);

  logic [RW-1:0]   amt;
  logic [DW-1:0]   ext;
  logic [2*DW-1:0] dbl;

  always_comb begin
    amt   = RW'({rot_i, 1'b0});
    ext   = DW'(imm_i);
    dbl   = {ext, ext} >> amt;
    val_o = dbl[DW-1:0];
    c_o   = (rot_i == 4'd0) ? carry_i : dbl[DW-1];
  end
endmodule

// File: rtl/opg_amt_sel.sv
module opg_amt_sel
  import opg_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = AMT_W
) (
  input  logic          reg_amt_i,
  input  logic [4:0]    imm5_i,
  input  logic [AW-1:0] rs_byte_i,
  input  shift_e        kind_i,
  output logic [AW-1:0] amt_o,
  output logic          rrx_o
);
  localparam logic [AW-1:0] FULL = AW'(DW);

  always_comb begin
    amt_o = '0;
    rrx_o = 1'b0;
    if (reg_amt_i) begin
      amt_o = rs_byte_i;
    end else if (imm5_i != 5'd0) begin
      amt_o = AW'(imm5_i);
    end else begin
      // zero immediate re-encodes a full-width shift or a one-bit carry rotate
      unique case (kind_i)
        SH_LSL:         amt_o = '0;
        SH_LSR, SH_ASR: amt_o = FULL;
        SH_ROR:         rrx_o = 1'b1;
        default:        amt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/opg_barrel.sv
module opg_barrel
  import opg_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = AMT_W
) (
  input  logic [DW-1:0] rm_i,
  input  logic [AW-1:0] amt_i,
  input  logic          rrx_i,
  input  shift_e        kind_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  localparam int unsigned    RW   = $clog2(DW);
  localparam logic [AW-1:0]  FULL = AW'(DW);

  logic [2*DW-1:0]        wide;
  logic signed [2*DW-1:0] swide;
  logic [AW-1:0]          sat;

  always_comb begin
    res_o = rm_i;
    c_o   = carry_i;
    wide  = '0;
    swide = '0;
    sat   = (amt_i > FULL) ? FULL : amt_i;
    if (rrx_i) begin
      res_o = {carry_i, rm_i[DW-1:1]};
      c_o   = rm_i[0];
    end else if (amt_i != '0) begin
      unique case (kind_i)
        SH_LSL: begin
          if (amt_i > FULL) begin
            res_o = '0;
            c_o   = 1'b0;
          end else begin
            wide  = {{DW{1'b0}}, rm_i} << amt_i;
            res_o = wide[DW-1:0];
            c_o   = wide[DW];
          end
        end
        SH_LSR: begin
          if (amt_i > FULL) begin
            res_o = '0;
            c_o   = 1'b0;
          end else begin
            wide  = {rm_i, {DW{1'b0}}} >> amt_i;
            res_o = wide[2*DW-1:DW];
            c_o   = wide[DW-1];
          end
        end
        SH_ASR: begin
          swide = $signed({rm_i, {DW{1'b0}}}) >>> sat;
          res_o = swide[2*DW-1:DW];
          c_o   = swide[DW-1];
        end
        SH_ROR: begin
          wide  = {rm_i, rm_i} >> amt_i[RW-1:0];
          res_o = wide[DW-1:0];
          c_o   = wide[DW-1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shifted_operand_gen.sv
module shifted_operand_gen
  import opg_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = AMT_W
) (
  input  logic [11:0]   op_field_i,
  input  logic          imm_form_i,
  input  logic [DW-1:0] rm_data_i,
  input  logic [AW-1:0] rs_byte_i,
  input  logic          carry_i,
  input  logic          flag_upd_i,
  input  logic          addr_mode_i,
  output logic [3:0]    rm_idx_o,
  output logic [3:0]    rs_idx_o,
  output logic [DW-1:0] operand_o,
  output logic          shift_c_o,
  output logic          carry_o,
  output logic          carry_we_o
);
  shift_e        kind;
  logic [AW-1:0] amt;
  logic          rrx;
  logic [DW-1:0] imm_val, sh_val;
  logic          imm_c, sh_c;

  assign kind     = shift_e'(op_field_i[6:5]);
  assign rm_idx_o = op_field_i[3:0];
  assign rs_idx_o = op_field_i[11:8];

  opg_imm_rot #(.DW(DW)) u_imm (
    .imm_i   (op_field_i[7:0]),
    .rot_i   (op_field_i[11:8]),
    .carry_i (carry_i),
    .val_o   (imm_val),
    .c_o     (imm_c)
  );

  opg_amt_sel #(.DW(DW), .AW(AW)) u_amt (
    .reg_amt_i (op_field_i[4]),
    .imm5_i    (op_field_i[11:7]),
    .rs_byte_i (rs_byte_i),
    .kind_i    (kind),
    .amt_o     (amt),
    .rrx_o     (rrx)
  );

  opg_barrel #(.DW(DW), .AW(AW)) u_sh (
    .rm_i    (rm_data_i),
    .amt_i   (amt),
    .rrx_i   (rrx),
    .kind_i  (kind),
    .carry_i (carry_i),
    .res_o   (sh_val),
    .c_o     (sh_c)
  );

  always_comb begin
    operand_o  = imm_form_i ? imm_val : sh_val;
    shift_c_o  = imm_form_i ? imm_c : sh_c;
    // address offsets never touch the flags
    carry_we_o = flag_upd_i & ~addr_mode_i;
    carry_o    = carry_we_o ? shift_c_o : carry_i;
  end
endmodule

// File: rtl/opg_checker.sv
module opg_checker #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8
) (
  input logic [11:0]   op_field_i,
  input logic          imm_form_i,
  input logic [DW-1:0] rm_data_i,
  input logic [AW-1:0] rs_byte_i,
  input logic          carry_i,
  input logic          flag_upd_i,
  input logic          addr_mode_i,
  input logic [3:0]    rm_idx_o,
  input logic [3:0]    rs_idx_o,
  input logic [DW-1:0] operand_o,
  input logic          shift_c_o,
  input logic          carry_o,
  input logic          carry_we_o
);
  always_comb begin
    if (addr_mode_i)
      p_addr_no_flag_r10: assert (!carry_we_o && carry_o == carry_i);
    if (!flag_upd_i)
      p_no_req_keep_r9: assert (carry_o == carry_i);
    if (carry_we_o)
      p_commit_shc_r9: assert (carry_o == shift_c_o);
    if (!imm_form_i && op_field_i[4] && rs_byte_i == '0)
      p_zero_amt_pass_r5: assert (operand_o == rm_data_i && shift_c_o == carry_i);
    if (!imm_form_i && op_field_i[4] && !op_field_i[6] && rs_byte_i > AW'(DW))
      p_logic_sat_r6: assert (operand_o == '0 && !shift_c_o);
    if (imm_form_i && op_field_i[11:8] == 4'd0)
      p_imm_norot_r1: assert (operand_o == DW'(op_field_i[7:0]) && shift_c_o == carry_i);
  end
endmodule

bind shifted_operand_gen opg_checker #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/shifted_operand_gen_tb.sv
module shifted_operand_gen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          req;
    logic [31:0] opnd;
    logic        shc;
    logic        cout;
    logic        we;
    logic [3:0]  rmi;
    logic [3:0]  rsi;
  } exp_t;

  logic        clk = 1'b0;
  logic [11:0] op_field;
  logic        imm_form, carry, flag_upd, addr_mode;
  logic [31:0] rm_data;
  logic [7:0]  rs_byte;
  logic [3:0]  rm_idx, rs_idx;
  logic [31:0] operand;
  logic        shift_c, carry_out, carry_we;
  logic [31:0] regs [16];
  exp_t        sb_q [$];
  int          n_vec = 0, n_fail = 0;
  bit          drained = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rm_data = regs[rm_idx];
  assign rs_byte = regs[rs_idx][7:0];

  shifted_operand_gen u_dut (
    .op_field_i (op_field), .imm_form_i (imm_form), .rm_data_i (rm_data),
    .rs_byte_i (rs_byte), .carry_i (carry), .flag_upd_i (flag_upd),
    .addr_mode_i (addr_mode), .rm_idx_o (rm_idx), .rs_idx_o (rs_idx),
    .operand_o (operand), .shift_c_o (shift_c), .carry_o (carry_out),
    .carry_we_o (carry_we)
  );

  // Bit-serial reference: one position per step, carry is the bit that leaves.
  function automatic logic [32:0] ref_shift(input logic [11:0] f, input logic immf,
                                            input logic [31:0] rm, input logic [7:0] rsb,
                                            input logic cin);
    logic [31:0] v;
    logic        c;
    int          n;
    logic [1:0]  k;
    c = cin;
    if (immf) begin
      v = {24'd0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      return {c, v};
    end
    v = rm;
    k = f[6:5];
    n = f[4] ? int'(rsb) : int'(f[11:7]);
    if (!f[4] && n == 0) begin
      if (k == 2'b01 || k == 2'b10) n = 32;
      else if (k == 2'b11) return {rm[0], cin, rm[31:1]};
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic drive(input int req, input logic [11:0] f, input logic immf,
                       input logic [31:0] rmv, input logic [31:0] rsv,
                       input logic cin, input logic fu, input logic am);
    exp_t        e;
    logic [32:0] r;
    @(posedge clk);
    regs[f[3:0]]  = rmv;
    regs[f[11:8]] = rsv;
    op_field = f; imm_form = immf; carry = cin; flag_upd = fu; addr_mode = am;
    r      = ref_shift(f, immf, regs[f[3:0]], regs[f[11:8]][7:0], cin);
    e.req  = req;
    e.opnd = r[31:0];
    e.shc  = r[32];
    e.we   = fu && !am;
    e.cout = e.we ? r[32] : cin;
    e.rmi  = f[3:0];
    e.rsi  = f[11:8];
    sb_q.push_back(e);
  endtask

  task automatic cmp(input int req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_vec++;
        cmp(e.req, "operand", operand, e.opnd);
        cmp(e.req, "shift_c", 32'(shift_c), 32'(e.shc));
        cmp(e.req, "carry", 32'(carry_out), 32'(e.cout));
        cmp(e.req, "carry_we", 32'(carry_we), 32'(e.we));
        cmp(2, "rm_idx", 32'(rm_idx), 32'(e.rmi));   // R2
        cmp(2, "rs_idx", 32'(rs_idx), 32'(e.rsi));   // R2
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!drained) begin
      n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < 16; i++) regs[i] = 32'h0;
    op_field = '0; imm_form = 0; carry = 0; flag_upd = 0; addr_mode = 0;
    // R1: rotated constants, rot 0 keeps carry_i, nonzero takes bit 31
    drive(1, 12'h0AB, 1, 0, 0, 1, 1, 0);
    drive(1, 12'h1FF, 1, 0, 0, 0, 1, 0);
    drive(1, 12'hF81, 1, 0, 0, 0, 1, 0);
    drive(1, 12'h401, 1, 0, 0, 1, 1, 0);
    // R2 / R4: each shift kind, immediate amount 4 (bits 11:7 = 4), rm in r3
    drive(4, 12'h203, 0, 32'h8000_000F, 0, 0, 1, 0);
    drive(4, 12'h223, 0, 32'h8000_000F, 0, 0, 1, 0);
    drive(4, 12'h243, 0, 32'h8000_000F, 0, 0, 1, 0);
    drive(4, 12'h263, 0, 32'h8000_000F, 0, 0, 1, 0);
    drive(4, 12'hF83, 0, 32'hC000_0001, 0, 1, 1, 0);   // LSL 31
    // R3: register amount from r5 low byte, upper bits ignored
    drive(3, 12'h532, 0, 32'h1234_5678, 32'hFFFF_FF08, 0, 1, 0);
    drive(3, 12'h572, 0, 32'h1234_5678, 32'h0000_0110, 1, 1, 0);
    // R5: zero amounts pass through with incoming carry
    drive(5, 12'h512, 0, 32'hDEAD_BEEF, 32'h0000_0100, 1, 1, 0);
    drive(5, 12'h572, 0, 32'hDEAD_BEEF, 32'h0, 1, 1, 0);
    drive(5, 12'h002, 0, 32'hDEAD_BEEF, 0, 1, 1, 0);
    // R6: saturation, amounts 32, 33, 200 and rotate by 32/64/37
    drive(6, 12'h512, 0, 32'h8000_0001, 32'd32, 0, 1, 0);
    drive(6, 12'h532, 0, 32'h8000_0001, 32'd32, 0, 1, 0);
    drive(6, 12'h512, 0, 32'h8000_0001, 32'd33, 1, 1, 0);
    drive(6, 12'h532, 0, 32'h8000_0001, 32'd200, 1, 1, 0);
    drive(6, 12'h552, 0, 32'h8000_0001, 32'd200, 0, 1, 0);
    drive(6, 12'h552, 0, 32'h7000_0001, 32'd40, 1, 1, 0);
    drive(6, 12'h572, 0, 32'h8000_0001, 32'd32, 0, 1, 0);
    drive(6, 12'h572, 0, 32'h0000_0002, 32'd64, 0, 1, 0);
    drive(6, 12'h572, 0, 32'h0000_0010, 32'd37, 0, 1, 0);
    // R7: immediate zero with logical/arithmetic right means 32
    drive(7, 12'h022, 0, 32'h8000_0000, 0, 0, 1, 0);
    drive(7, 12'h042, 0, 32'h8000_0000, 0, 0, 1, 0);
    // R8: immediate zero rotate is one-bit rotate through carry
    drive(8, 12'h062, 0, 32'h0000_0003, 0, 1, 1, 0);
    drive(8, 12'h062, 0, 32'h8000_0002, 0, 0, 1, 0);
    // R9: no update request keeps the incoming carry
    drive(9, 12'h0A3, 0, 32'h0000_00FF, 0, 0, 0, 0);
    drive(9, 12'h1FF, 1, 0, 0, 0, 0, 0);
    // R10: address offset never writes carry, even with a request
    drive(10, 12'h0A3, 0, 32'h0000_00FF, 0, 0, 1, 1);
    drive(10, 12'h0A3, 0, 32'h0000_00FF, 0, 1, 1, 1);
    drive(10, 12'h1FF, 1, 0, 0, 0, 1, 1);
    // R4: mixed random sweep across all forms
    for (int i = 0; i < 400; i++)
      drive(4, 12'($urandom), 1'($urandom), $urandom, $urandom & 32'h0000_003F,
            1'($urandom), 1'($urandom), 1'($urandom));
    wait (sb_q.size() == 0);
    @(posedge clk);
    drained = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule